// File: doc/BRIEF.md
# Packed Half-Precision Reciprocal Estimator

This unit takes a vector of IEEE half-precision (FP16) lanes and writes back a reciprocal estimate for each one. The vector length can be 128, 256 or 512 bits, which gives 8, 16 or 32 lanes. A per-lane write mask picks which lanes are updated. Unselected lanes either keep the previous destination value (merge) or are cleared (zeroing). A broadcast control feeds lane 0 of the source to every lane.

Each lane is a combinational estimator. It handles normal and subnormal operands and the special encodings. The lane results then pass through the mask and length selection, and the whole vector is captured in one output register. A valid/ready handshake sits in front of that register. A result is offered on the cycle after its operands are accepted, and it is held while the consumer stalls. No exception flags exist.

Top module: `fp16_recip_vec`

## Requirements
- R1: `vlen_sel` sets the active lane count: 0 gives 8 lanes, 1 gives 16, and 2 or 3 give 32. Every destination bit above the active lanes is 0.
- R2: An active lane is written with the reciprocal estimate of its operand. A lane is active when it is in range and either `mask_en` is 0 or its `wmask` bit is 1. Lane i occupies bits [16i+15:16i].
- R3: An in-range inactive lane is written with 0 when `zero_mask` is 1. Otherwise it is written with the same lane of `dst_old`.
- R4: When `bcast` is 1, every lane takes source lane 0 (bits [15:0]) as its operand.
- R5: Operands use FP16 layout: sign in bit 15, biased exponent (bias 15) in bits 14:10, fraction in bits 9:0. For finite nonzero operands, the result carries the operand's sign. A result in the normal range is within a relative error below 2^-11 + 2^-14. A result below the normal range is the nearest subnormal, within 2^-25.
- R6: An operand that is an exact power of two, normal or subnormal (and larger than 2^-16), produces exactly the reciprocal power of two.
- R7: An operand of ±0, or a subnormal with magnitude at most 2^-16 (fraction ≤ 0x100), produces infinity (exponent 31, fraction 0) with the operand's sign.
- R8: An operand of ±infinity produces zero with the operand's sign.
- R9: A NaN operand produces the same encoding with fraction bit 9 (the quiet bit) set. Sign and the rest of the payload are kept.
- R10: A subnormal operand larger than 2^-16 is normalized before estimation and produces a finite result that meets R5 or R6.
- R11: `in_ready` is 1 whenever the output register is empty or `out_ready` is 1. An accepted vector appears at `out_valid` on the next cycle. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `dst` stay unchanged.
- R12: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand vector offered |
| in_ready | output | 1 | Unit can take an operand vector |
| vlen_sel | input | 2 | Vector length: 0=128, 1=256, 2/3=512 bits |
| mask_en | input | 1 | Apply `wmask`; when 0 every in-range lane is active |
| zero_mask | input | 1 | Inactive lanes cleared (1) or merged from `dst_old` (0) |
| bcast | input | 1 | Use source lane 0 for every lane |
| wmask | input | 32 | Per-lane write mask |
| src | input | 512 | Source FP16 lanes |
| dst_old | input | 512 | Prior destination value for merging |
| out_valid | output | 1 | Result vector available |
| out_ready | input | 1 | Consumer takes the result |
| dst | output | 512 | Result FP16 lanes |

## Verification
Every one of the 65536 FP16 encodings is sent through the full-width, unmasked path once. This sweep separates the special classes: NaNs, infinities, zeros, subnormals at or below the 2^-16 threshold, subnormals above it, and exact powers of two. It also covers ordinary normals, whose results are held to the error bound with real arithmetic.

Random vectors with random masks are then sent under all three lengths, under merge and zeroing, and with broadcast. These runs separate lane selection from estimation: they show whether old data, zeros or a wrong source lane reach a lane. Throughout these runs the consumer stalls at random, which exposes dropped, duplicated or altered results in the output register.

// File: rtl/fp16_recip_pkg.sv
package fp16_recip_pkg;

    localparam int HW = 16;

    typedef struct packed {
        logic       sgn;
        logic [4:0] exp;
        logic [9:0] frac;
    } half_t;

    typedef enum logic [1:0] {
        VL_128 = 2'd0,
        VL_256 = 2'd1,
        VL_512 = 2'd2,
        VL_ALT = 2'd3
    } vlen_e;

    // index of the highest set bit of a nonzero fraction
    function automatic logic [3:0] top_bit(input logic [9:0] v);
        logic [3:0] idx;
        idx = 4'd0;
        for (int b = 0; b < 10; b++) begin
            if (v[b]) idx = 4'(b);
        end
        return idx;
    endfunction

    function automatic int unsigned lanes_for(input logic [1:0] sel, input int unsigned maxl);
        int unsigned n;
        case (vlen_e'(sel))
            VL_128:  n = 8;
            VL_256:  n = 16;
            default: n = 32;
        endcase
        return (n > maxl) ? maxl : n;
    endfunction

endpackage

// File: rtl/fp16_recip_lane.sv
module fp16_recip_lane
    import fp16_recip_pkg::*;
(
    input  logic [15:0] x,
    output logic [15:0] y
);
    localparam logic [33:0] NUMER   = 34'h1_0000_0000;
    localparam logic [9:0]  TINY_FR = 10'h100;

    half_t             h;
    logic              is_nan, is_inf, is_tiny;
    logic [3:0]        lead;
    logic [10:0]       mant;
    logic signed [7:0] ee, eb, ebn;
    logic [33:0]       quo;
    logic              top, rb;
    logic [10:0]       msel;
    logic [22:0]       dsh;
    logic [4:0]        shr;
    logic [14:0]       pk;

    assign h       = half_t'(x);
    assign is_nan  = (h.exp == 5'h1F) && (h.frac != 10'd0);
    assign is_inf  = (h.exp == 5'h1F) && (h.frac == 10'd0);
    assign is_tiny = (h.exp == 5'h00) && (h.frac <= TINY_FR);
    assign lead    = top_bit(h.frac);

    always_comb begin
        if (h.exp == 5'd0) begin
            mant = 11'({1'b0, h.frac} << (4'd10 - lead));
            ee   = 8'(signed'({4'd0, lead})) - 8'sd9;
        end else begin
            mant = {1'b1, h.frac};
            ee   = 8'(signed'({3'd0, h.exp}));
        end
        eb  = 8'sd29 - ee;
        quo = NUMER / {23'd0, (mant == 11'd0) ? 11'd1 : mant};
        top = quo[22];
        ebn = eb + 8'(signed'({7'd0, top}));
        msel = 11'd0;
        dsh  = 23'd0;
        shr  = 5'd12;
        if (ebn > 8'sd0) begin
            msel = top ? quo[22:12] : quo[21:11];
            rb   = top ? 1'b0 : quo[10];
            pk   = {ebn[4:0], msel[9:0]} + 15'(rb);
        end else begin
            shr  = (eb == 8'sd0) ? 5'd12 : 5'd13;
            dsh  = quo[22:0] >> shr;
            rb   = quo[shr - 5'd1];
            pk   = {5'd0, dsh[9:0]} + 15'(rb);
        end
        if (is_nan)       y = x | 16'h0200;
        else if (is_inf)  y = {h.sgn, 15'd0};
        else if (is_tiny) y = {h.sgn, 5'h1F, 10'd0};
        else              y = {h.sgn, pk};
    end
endmodule

// File: rtl/fp16_recip_merge.sv
module fp16_recip_merge (
    input  logic        in_range,
    input  logic        active,
    input  logic        zeroing,
    input  logic [15:0] est,
    input  logic [15:0] old,
    output logic [15:0] res
);
    always_comb begin
        if (!in_range)    res = 16'd0;
        else if (active)  res = est;
        else if (zeroing) res = 16'd0;
        else              res = old;
    end
endmodule

// File: rtl/fp16_recip_vec.sv
module fp16_recip_vec
    import fp16_recip_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [1:0]          vlen_sel,
    input  logic                mask_en,
    input  logic                zero_mask,
    input  logic                bcast,
    input  logic [LANES-1:0]    wmask,
    input  logic [LANES*16-1:0] src,
    input  logic [LANES*16-1:0] dst_old,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [LANES*16-1:0] dst
);
    localparam int VW = LANES * HW;

    logic [VW-1:0] nxt;
    int unsigned   klanes;

    assign klanes   = lanes_for(vlen_sel, LANES);
    assign in_ready = !out_valid || out_ready;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [15:0] opnd, est;
        assign opnd = bcast ? src[15:0] : src[i*HW +: HW];
        fp16_recip_lane u_est (.x(opnd), .y(est));
        fp16_recip_merge u_sel (
            .in_range (i < klanes),
            .active   (!mask_en || wmask[i]),
            .zeroing  (zero_mask),
            .est      (est),
            .old      (dst_old[i*HW +: HW]),
            .res      (nxt[i*HW +: HW])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dst       <= '0;
        end else begin
            if (in_ready) out_valid <= in_valid;
            if (in_valid && in_ready) dst <= nxt;
        end
    end
endmodule

// File: rtl/fp16_recip_chk.sv
module fp16_recip_chk #(
    parameter int LANES = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [1:0]          vlen_sel,
    input logic                mask_en,
    input logic                zero_mask,
    input logic                lane0_mask,
    input logic [15:0]         src0,
    input logic [LANES*16-1:0] dst
);
    logic take;
    assign take = in_valid && in_ready;

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(dst));

    a_r11_accept: assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid);

    a_r1_upper: assert property (@(posedge clk) disable iff (rst)
        take && vlen_sel == 2'd0 |=> dst[LANES*16-1:128] == '0);

    a_r3_zero: assert property (@(posedge clk) disable iff (rst)
        take && mask_en && zero_mask && !lane0_mask |=> dst[15:0] == 16'h0000);

    a_r7_inf: assert property (@(posedge clk) disable iff (rst)
        take && !mask_en && src0[14:0] == 15'd0 |=> dst[14:0] == 15'h7C00);

    a_r8_zero: assert property (@(posedge clk) disable iff (rst)
        take && !mask_en && src0[14:0] == 15'h7C00 |=> dst[14:0] == 15'd0);

    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        take && !mask_en && src0[14:10] == 5'h1F && src0[9:0] != 10'd0
        |=> dst[15:0] == ($past(src0) | 16'h0200));
endmodule

bind fp16_recip_vec fp16_recip_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .vlen_sel   (vlen_sel),
    .mask_en    (mask_en),
    .zero_mask  (zero_mask),
    .lane0_mask (wmask[0]),
    .src0       (src[15:0]),
    .dst        (dst)
);

// File: tb/test_fp16_recip_vec.sv
module test_fp16_recip_vec;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 32;
    localparam int VW = NL * 16;

    typedef struct {
        logic [VW-1:0] s, o;
        logic [NL-1:0] m;
        logic          me, zm, bc;
        logic [1:0]    vl;
    } tx_t;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
    logic [1:0] vlen_sel = 2'd2;
    logic mask_en = 1'b0, zero_mask = 1'b0, bcast = 1'b0;
    logic [NL-1:0] wmask = '0;
    logic [VW-1:0] src = '0, dst_old = '0, dst;

    int n_cmp = 0, n_bad = 0;
    bit stall_mode = 1'b0, finished = 1'b0, hold_chk = 1'b0;
    logic [VW-1:0] hold_dst;
    tx_t cur, q[$];

    fp16_recip_vec #(.LANES(NL)) i_fp16_recip_vec (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .vlen_sel(vlen_sel), .mask_en(mask_en), .zero_mask(zero_mask),
        .bcast(bcast), .wmask(wmask), .src(src), .dst_old(dst_old),
        .out_valid(out_valid), .out_ready(out_ready), .dst(dst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic real p2(input int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic real mag(input logic [15:0] h);
        if (h[14:10] == 5'd0) return real'(h[9:0]) * p2(-24);
        return real'(1024 + int'(h[9:0])) * p2(int'(h[14:10]) - 25);
    endfunction

    // returns "" when y is an acceptable result for x, else the requirement tag
    function automatic string lane_chk(input logic [15:0] x, input logic [15:0] y);
        logic [4:0] xe = x[14:10];
        logic [9:0] xf = x[9:0];
        real ex, yv, err;
        bit pw;
        if (xe == 5'h1F && xf != 0) return (y == (x | 16'h0200)) ? "" : "R9";
        if (xe == 5'h1F) return (y == {x[15], 15'd0}) ? "" : "R8";
        if (xe == 5'd0 && xf <= 10'h100) return (y == {x[15], 5'h1F, 10'd0}) ? "" : "R7";
        if (y[15] != x[15] || y[14:10] == 5'h1F) return (xe == 0) ? "R10" : "R5";
        ex = 1.0 / mag(x);
        yv = mag(y);
        pw = (xe != 0) ? (xf == 0) : ((xf & (xf - 10'd1)) == 0);
        if (pw) return (yv == ex) ? "" : "R6";
        err = (yv > ex) ? yv - ex : ex - yv;
        if (y[14:10] != 0) begin
            if (err / ex < p2(-11) + p2(-14)) return "";
        end else begin
            if (err <= p2(-25) * 1.000001) return "";
        end
        return (xe == 0) ? "R10" : "R5";
    endfunction

    task automatic check_tx(input tx_t t, input logic [VW-1:0] got);
        int kl = (t.vl == 2'd0) ? 8 : (t.vl == 2'd1) ? 16 : 32;
        bit bad = 1'b0;
        n_cmp++;
        for (int i = 0; i < NL && !bad; i++) begin
            logic [15:0] g = got[i*16 +: 16];
            logic [15:0] x = t.bc ? t.s[15:0] : t.s[i*16 +: 16];
            string tag;
            if (i >= kl) begin
                if (g != 16'd0) begin
                    $display("FAIL R1 lane %0d got %h expected 0000", i, g); bad = 1'b1;
                end
            end else if (!t.me || t.m[i]) begin
                tag = lane_chk(x, g);
                if (tag != "") begin
                    if (t.bc) tag = {"R4/", tag};
                    else if (!t.me) tag = {"R2/", tag};
                    $display("FAIL %s lane %0d src %h got %h expected ~%g", tag, i, x, g, 1.0 / mag(x));
                    bad = 1'b1;
                end
            end else if (t.zm) begin
                if (g != 16'd0) begin
                    $display("FAIL R3 zeroed lane %0d got %h expected 0000", i, g); bad = 1'b1;
                end
            end else if (g != t.o[i*16 +: 16]) begin
                $display("FAIL R3 merged lane %0d got %h expected %h", i, g, t.o[i*16 +: 16]); bad = 1'b1;
            end
        end
        if (bad) n_bad++;
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // reference model: queue of accepted vectors, compared at every transfer
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (hold_chk) begin
                n_cmp++;
                if (!out_valid || dst !== hold_dst) begin
                    n_bad++;
                    $display("FAIL R11 stalled output changed: valid %b, expected 1 with held data", out_valid);
                end
            end
            hold_chk = out_valid && !out_ready;
            hold_dst = dst;
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R11 output with no accepted input: got valid 1 expected 0");
                end else check_tx(q.pop_front(), dst);
            end
            if (in_valid && in_ready) q.push_back(cur);
        end
    end

    always @(negedge clk) out_ready = stall_mode ? (($urandom % 4) != 0) : 1'b1;

    task automatic send(input tx_t t);
        @(negedge clk);
        cur = t;
        src = t.s; dst_old = t.o; wmask = t.m; mask_en = t.me;
        zero_mask = t.zm; bcast = t.bc; vlen_sel = t.vl; in_valid = 1'b1;
        #2;
        while (!in_ready) begin @(negedge clk); #2; end
    endtask

    task automatic idle;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic drain;
        for (int k = 0; k < 200 && q.size() != 0; k++) @(negedge clk);
        n_cmp++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R11 %0d results never delivered, expected 0", q.size());
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: got hang, expected completion");
        report();
    end

    initial begin
        tx_t t;
        repeat (3) @(negedge clk);
        #2;
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++; $display("FAIL R12 in reset out_valid got %b expected 0", out_valid);
        end
        @(negedge clk); rst = 1'b0; #2;
        n_cmp++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_bad++; $display("FAIL R12 after reset valid/ready got %b%b expected 01", out_valid, in_ready);
        end

        // R11 latency: one vector, result one cycle later
        t.s = '0; t.o = rnd_vec(); t.m = '0; t.me = 1'b0; t.zm = 1'b0; t.bc = 1'b0; t.vl = 2'd2;
        send(t); idle(); #2;
        n_cmp++;
        if (out_valid !== 1'b1) begin
            n_bad++; $display("FAIL R11 latency: out_valid got %b expected 1", out_valid);
        end
        drain();

        // R5..R10 and R2: every FP16 encoding, full width, unmasked
        for (int b = 0; b < 65536 / NL; b++) begin
            for (int i = 0; i < NL; i++) t.s[i*16 +: 16] = 16'(b * NL + i);
            t.o = rnd_vec();
            send(t);
        end
        idle(); drain();

        // R1, R3, R4, R11: masks, lengths, merge/zero, broadcast under stalls
        stall_mode = 1'b1;
        for (int k = 0; k < 600; k++) begin
            t.s = rnd_vec(); t.o = rnd_vec(); t.m = $urandom;
            t.me = (k % 5) != 0;
            t.zm = (k % 3) == 1;
            t.bc = (k % 4) == 2;
            t.vl = 2'(k % 4);
            send(t);
            if (k % 7 == 0) idle();
        end
        idle(); drain();
        stall_mode = 1'b0;
        repeat (3) @(negedge clk);
        report();
    end
endmodule